// File: doc/BRIEF.md
# SPI Register Access Port

This block lets an external SPI master read and write a bank of 128 eight-bit configuration registers. A transfer begins when the master pulls the active-low select line low. The first byte carries an opcode and the second byte carries a register address. Every byte after that is data. Each data byte goes to the next register, because an internal address counter steps forward after every complete data byte for as long as select stays low. A single transfer can therefore fill or dump a run of consecutive registers.

The serial pins are sampled in the system clock domain through synchronisers, so SCK must run well below the system clock. Eight system clocks per SCK half period or more is comfortable. The port uses SPI mode 0 with the most significant bit first. The output pad is tri-stated by an enable output that the pad ring uses.

Top module: `spi_reg_port`

## Requirements
- R1: After reset every register reads back as 0x00.
- R2: The port works in SPI mode 0, MSB first. MOSI is captured on rising SCK edges. The MISO data bit changes only after falling SCK edges, so it is stable when the master samples it at the next rising edge.
- R3: Command byte 0x03 selects a read. The next byte is an address, of which only bits 6:0 are used and bit 7 is ignored. The first data byte shifted out is the register at that address.
- R4: Command byte 0x02 selects a write. The next byte is an address, with bits 6:0 used. The first complete data byte is stored in the register at that address.
- R5: In a write, each further complete data byte goes to the next higher register address while select stays low.
- R6: In a read, each further data byte shifted out comes from the next higher register address while select stays low.
- R7: During a burst the address counter wraps from 127 to 0.
- R8: A command byte other than 0x02 or 0x03 causes every following byte to be ignored until select goes high. No register changes.
- R9: Raising select ends the transfer and discards any incomplete data byte. The next transfer starts again with a command byte.
- R10: spi_miso_oe is high exactly while spi_cs_n is low. spi_miso reads 0 while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |

## Verification
The bench aims at bursts that cross from register 127 to register 0. A counter that saturates or has the wrong width would rewrite register 127, or read it again, instead of moving on to register 0. It ends a write burst part-way through a byte. A design that commits partial bytes, or that keeps its bit count across select edges, would corrupt a register or shift later transfers out of frame. It sends opcodes that are neither read nor write and then reads back the whole bank, which catches any decode that falls through to a write. It also sets the ignored top bit of the address byte, which exposes a design that uses the full byte as the address.

// File: rtl/spi_reg_pkg.sv
// Package: shared sizes, opcodes and the transfer phase type for the
// SPI register access port. Assumes an 8-bit command and data byte.
package spi_reg_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int NUM_REGS = 1 << ADDR_W;

    localparam logic [DATA_W-1:0] OPC_READ  = 8'h03;
    localparam logic [DATA_W-1:0] OPC_WRITE = 8'h02;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR_RD,
        PH_ADDR_WR,
        PH_READ,
        PH_WRITE,
        PH_IGNORE
    } phase_t;
endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings asynchronous serial pins into the clk domain through a chain of
// flops. It gives the synchronised value and a copy delayed by one more
// cycle, which the caller uses for edge detection.
// Assumes each pin stays stable for several clk cycles.
module spi_pin_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] chain_q [STAGES+1];

    // Purpose: first synchroniser flop captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= RESET_VAL;
        else        chain_q[0] <= pin_i;
    end

    generate
        for (genvar s = 1; s <= STAGES; s++) begin : g_stage
            // Purpose: each later stage resolves metastability or delays for edges.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q[s] <= RESET_VAL;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/spi_reg_bank.sv
// Module: spi_reg_bank
// Register file of NUM_REGS bytes. It has one synchronous write port and
// one combinational read port. Every register clears to zero in reset.
module spi_reg_bank
    import spi_reg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem_q [DEPTH];

    // Purpose: clear the bank in reset, otherwise store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R4: a write strobe leaves the byte in the addressed register.
    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem_q[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/spi_frame_ctrl.sv
// Module: spi_frame_ctrl
// Frame engine. It counts bits, assembles bytes, decodes the opcode,
// loads and advances the address counter, makes write strobes and
// shifts read data out. Its inputs are synchronised pins and one-cycle
// SCK edge pulses. It assumes at most one edge pulse per clk cycle.
module spi_frame_ctrl
    import spi_reg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    localparam int CNT_W = $clog2(DW),
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DW - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_act,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          mosi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] reg_addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          miso_bit
);
    phase_t           phase_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic [DW-2:0]    rx_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    tx_q;
    logic [DW-1:0]    rx_byte;
    logic             byte_done;

    assign rx_byte   = {rx_q, mosi_s};
    assign byte_done = sel_act && sck_rise && (bit_cnt_q == LAST_BIT);

    // Purpose: bit counting, byte assembly, phase sequencing and address counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_CMD;
            bit_cnt_q <= '0;
            rx_q      <= '0;
            addr_q    <= '0;
        end else if (!sel_act) begin
            phase_q   <= PH_CMD;
            bit_cnt_q <= '0;
        end else if (sck_rise) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            rx_q      <= rx_byte[DW-2:0];
            if (bit_cnt_q == LAST_BIT) begin
                unique case (phase_q)
                    PH_CMD: begin
                        if (rx_byte == OPC_READ)       phase_q <= PH_ADDR_RD;
                        else if (rx_byte == OPC_WRITE) phase_q <= PH_ADDR_WR;
                        else                           phase_q <= PH_IGNORE;
                    end
                    PH_ADDR_RD: begin
                        addr_q  <= rx_byte[AW-1:0];
                        phase_q <= PH_READ;
                    end
                    PH_ADDR_WR: begin
                        addr_q  <= rx_byte[AW-1:0];
                        phase_q <= PH_WRITE;
                    end
                    PH_READ, PH_WRITE: addr_q <= addr_q + 1'b1;
                    default: phase_q <= PH_IGNORE;
                endcase
            end
        end
    end

    // Purpose: load a read byte at each byte boundary and shift on falling SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q <= '0;
        end else if (sck_fall) begin
            if (phase_q == PH_READ && bit_cnt_q == '0) tx_q <= rd_data;
            else                                       tx_q <= {tx_q[DW-2:0], 1'b0};
        end
    end

    assign reg_addr = addr_q;
    assign wr_en    = byte_done && (phase_q == PH_WRITE);
    assign wr_data  = rx_byte;
    assign miso_bit = tx_q[DW-1];

    // R2: the outgoing shift register moves only after a falling SCK edge.
    p_tx_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(tx_q));
    // R7: a burst step from the top register lands on register 0.
    p_addr_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && (phase_q == PH_READ || phase_q == PH_WRITE) && (&addr_q))
        |=> addr_q == '0);
    // R8: once an unknown opcode is seen, no write strobe appears.
    p_ignore_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IGNORE) |-> !wr_en);
    // R9: after select is released the frame restarts at a command byte.
    p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_act |=> (phase_q == PH_CMD && bit_cnt_q == '0));
endmodule

// File: rtl/spi_reg_port.sv
// Module: spi_reg_port (top)
// An SPI mode 0 slave that gives read and write access, with burst
// auto-increment, to a bank of byte registers. It assumes SCK runs at
// least several times slower than clk.
module spi_reg_port
    import spi_reg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    logic [2:0]    pins_s, pins_p;
    logic          sck_rise, sck_fall, sel_act;
    logic [AW-1:0] reg_addr;
    logic          wr_en;
    logic [DW-1:0] wr_data, rd_data;
    logic          miso_bit;

    spi_pin_sync #(
        .WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b010)
    ) u_sync (
        .clk(clk), .rst_n(rst_n),
        .pin_i({spi_mosi, spi_cs_n, spi_sck}),
        .sync_o(pins_s), .prev_o(pins_p)
    );

    assign sck_rise = pins_s[0] & ~pins_p[0];
    assign sck_fall = ~pins_s[0] & pins_p[0];
    assign sel_act  = ~pins_s[1];

    spi_frame_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_act(sel_act),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(pins_s[2]),
        .rd_data(rd_data), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .miso_bit(miso_bit)
    );

    spi_reg_bank #(.AW(AW), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(reg_addr),
        .wr_data(wr_data), .rd_addr(reg_addr), .rd_data(rd_data)
    );

    assign spi_miso_oe = ~spi_cs_n;
    assign spi_miso    = spi_miso_oe & miso_bit;

    // R10: the pad is never driven while select is high.
    p_oe_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (!spi_miso_oe && !spi_miso));
endmodule

// File: tb/test_spi_reg_port.sv
module test_spi_reg_port;
    localparam int HALF = 8;
    logic clk = 0, rst_n = 0;
    logic sck = 0, cs_n = 1, mosi = 0;
    logic miso, miso_oe;
    int checks = 0, errors = 0;
    logic [7:0] model [128];

    always #10 clk = ~clk;

    spi_reg_port i_spi_reg_port (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .spi_miso_oe(miso_oe)
    );

    function automatic logic [6:0] next_addr(input logic [6:0] a);
        return a + 7'd1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1;
            repeat (HALF) @(negedge clk);
            sck = 0;
        end
    endtask

    task automatic sel_on();
        cs_n = 0;
        repeat (HALF) @(negedge clk);
        check("R10 oe during select", int'(miso_oe), 1);
    endtask

    task automatic sel_off();
        repeat (HALF) @(negedge clk);
        cs_n = 1;
        repeat (HALF) @(negedge clk);
        check("R10 oe idle", int'(miso_oe), 0);
        check("R10 miso idle", int'(miso), 0);
    endtask

    task automatic do_write(input logic [7:0] abyte, input int len);
        logic [7:0] rx, d;
        logic [6:0] a;
        a = abyte[6:0];
        sel_on();
        xfer(8'h02, rx);
        xfer(abyte, rx);
        for (int k = 0; k < len; k++) begin
            d = 8'($urandom);
            xfer(d, rx);
            model[a] = d;
            a = next_addr(a);
        end
        sel_off();
    endtask

    task automatic do_read(input logic [7:0] abyte, input int len, input string req);
        logic [7:0] rx;
        logic [6:0] a;
        a = abyte[6:0];
        sel_on();
        xfer(8'h03, rx);
        xfer(abyte, rx);
        for (int k = 0; k < len; k++) begin
            xfer(8'h00, rx);
            if (k == 0) check({req, " R3 first read byte"}, int'(rx), int'(model[a]));
            else if (a == 7'd0) check({req, " R7 wrapped read byte"}, int'(rx), int'(model[a]));
            else check({req, " R6 burst read byte"}, int'(rx), int'(model[a]));
            a = next_addr(a);
        end
        sel_off();
    endtask

    task automatic do_bad(input logic [7:0] opc, input int len);
        logic [7:0] rx;
        sel_on();
        xfer(opc, rx);
        for (int k = 0; k < len; k++) xfer(8'($urandom), rx);
        sel_off();
    endtask

    initial begin
        logic [7:0] rx;
        logic [7:0] opc;
        int unused;
        unused = int'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        check("R10 oe after reset", int'(miso_oe), 0);
        // R1: whole bank reads zero after reset
        do_read(8'h00, 128, "R1 reset");

        // R4/R5/R7: burst write across the top of the bank, address bit 7 set
        do_write(8'hFE, 4);
        do_read(8'h7D, 6, "R5 R7 wrap");

        // R9: a partial byte at the end of a write is discarded
        sel_on();
        xfer(8'h02, rx);
        xfer(8'h10, rx);
        xfer(8'hA5, rx);
        model[16] = 8'hA5;
        for (int i = 7; i >= 4; i--) begin
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1;
            repeat (HALF) @(negedge clk);
            sck = 0;
        end
        sel_off();
        do_read(8'h10, 2, "R9 partial");

        // R8: unknown opcodes change nothing, including opcodes one bit off
        do_bad(8'h01, 4);
        do_bad(8'h82, 3);
        do_bad(8'h00, 2);
        do_read(8'h00, 128, "R8 ignore");

        // random mix of writes, reads and bad opcodes
        for (int t = 0; t < 40; t++) begin
            int kind;
            kind = int'($urandom_range(0, 4));
            if (kind <= 1) do_write(8'($urandom), int'($urandom_range(1, 5)));
            else if (kind <= 3) do_read(8'($urandom), int'($urandom_range(1, 5)), "R4 random");
            else begin
                opc = 8'($urandom);
                if (opc == 8'h02 || opc == 8'h03) opc = 8'hFF;
                do_bad(opc, int'($urandom_range(1, 4)));
            end
        end
        do_read(8'h00, 128, "R2 final");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule